// File: doc/BRIEF.md
# Programmable bit-rate clock divider

The divider counts cycles of the clock recovered from the RF carrier and emits the bit timing for an uplink modulator. Each bit period lasts a programmable number of carrier cycles. At the last cycle of each period the divider raises a one-cycle bit strobe. Half way through each period it raises a one-cycle half strobe. Encoders that need a transition in the middle of a bit use the half strobe.

The period is set by one of two configuration modes. In basic mode the low three bits of the rate field pick one of eight fixed ratios, and some of those ratios are not powers of two. In extended mode the full six-bit field gives any even ratio from 2 to 128. A change to the mode or the rate field during a period does not affect that period. The divider samples its configuration only when a new period starts, so it never produces a truncated or stretched bit.

Top module: `bitrate_div`

## Requirements
- R1: While rst_ni is low, the period counter is held at zero and bit_stb_o is low. After release, the first bit_stb_o is high in the R-th cycle, where R is the selected ratio, and the cycles are counted from the first rising edge after release.
- R2: When ext_mode_i is 0 (basic mode), rate_i[2:0] codes 0 to 7 select ratios of 8, 16, 32, 40, 50, 64, 100 and 128 respectively.
- R3: In basic mode, rate_i[5:3] has no effect on either strobe.
- R4: When ext_mode_i is 1 (extended mode), rate_i value n selects a ratio of 2n+2. Code 0 gives 2 and code 63 gives 128.
- R5: bit_stb_o is high for exactly one cycle in every R cycles.
- R6: half_stb_o is high for exactly one cycle in each period, in its (R/2)-th cycle. It never coincides with bit_stb_o.
- R7: The divider samples ext_mode_i and rate_i only in the first cycle of each period. A change made later in a period takes effect from the next period.
- R8: Every bit period is even in length and no longer than 128 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock recovered from the RF carrier |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 0 selects basic mode, 1 selects extended mode |
| rate_i | input | 6 | Rate code; basic mode reads bits 2:0 only |
| bit_stb_o | output | 1 | One-cycle strobe in the last cycle of each bit period |
| half_stb_o | output | 1 | One-cycle strobe at the middle of each bit period |

## Verification
The hardest case to reach from the ports is a rate change that arrives part way through a period. It must leave the current period untouched and then govern the next one. The bench gets there by starting a long period and switching to a short one a few cycles in. It also switches modes at irregular intervals, so that changes land both at boundaries and mid-period. A cycle-level arithmetic model of the counter predicts every strobe. The bench also sweeps all eight basic codes, with junk in the upper bits, and all 64 extended codes, which covers the shortest and longest periods.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;
  parameter int unsigned RATE_W  = 6;
  parameter int unsigned RATIO_W = 8;

  typedef logic [RATIO_W-1:0] ratio_t;

  function automatic ratio_t basic_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return ratio_t'(8);
      3'd1:    return ratio_t'(16);
      3'd2:    return ratio_t'(32);
      3'd3:    return ratio_t'(40);
      3'd4:    return ratio_t'(50);
      3'd5:    return ratio_t'(64);
      3'd6:    return ratio_t'(100);
      default: return ratio_t'(128);
    endcase
  endfunction

  function automatic ratio_t ext_ratio(input logic [RATE_W-1:0] n);
    return ratio_t'({1'b0, n, 1'b0}) + ratio_t'(2);
  endfunction
endpackage

// File: rtl/bitrate_sel.sv
module bitrate_sel
  import bitrate_pkg::*;
#(
  parameter int unsigned RW = RATE_W
) (
  input  logic          ext_mode_i,
  input  logic [RW-1:0] rate_i,
  output ratio_t        ratio_o
);
  localparam int unsigned CODE_W = 3;

  ratio_t basic_r, ext_r;

  always_comb basic_r = basic_ratio(rate_i[CODE_W-1:0]);
  always_comb ext_r   = ext_ratio(rate_i);
  always_comb ratio_o = ext_mode_i ? ext_r : basic_r;
endmodule

// File: rtl/bitrate_ctr.sv
module bitrate_ctr
  import bitrate_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t live_ratio_i,
  output logic   bit_stb_o,
  output logic   half_stb_o
);
  localparam ratio_t ONE = ratio_t'(1);

  ratio_t cnt_q, held_q, act_ratio;
  logic   at_start;

  // the first cycle of a period uses the live ratio, the rest use the latched copy
  always_comb at_start  = (cnt_q == '0);
  always_comb act_ratio = at_start ? live_ratio_i : held_q;

  always_comb begin
    bit_stb_o  = (cnt_q == act_ratio - ONE);
    half_stb_o = (cnt_q == (act_ratio >> 1) - ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      held_q <= ratio_t'(2);
    end else begin
      if (at_start) held_q <= live_ratio_i;
      cnt_q <= bit_stb_o ? '0 : cnt_q + ONE;
    end
  end
endmodule

// File: rtl/bitrate_div.sv
module bitrate_div
  import bitrate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              bit_stb_o,
  output logic              half_stb_o
);
  ratio_t live_ratio;

  bitrate_sel #(.RW(RATE_W)) u_sel (
    .ext_mode_i (ext_mode_i),
    .rate_i     (rate_i),
    .ratio_o    (live_ratio)
  );

  bitrate_ctr u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .live_ratio_i (live_ratio),
    .bit_stb_o    (bit_stb_o),
    .half_stb_o   (half_stb_o)
  );
endmodule

// File: rtl/bitrate_div_chk.sv
module bitrate_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_stb_o,
  input logic half_stb_o
);
  logic [7:0] gap_q;
  logic       half_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= '0;
      half_seen_q <= 1'b0;
    end else begin
      gap_q <= bit_stb_o ? 8'd0 : gap_q + 8'd1;
      if (bit_stb_o)       half_seen_q <= 1'b0;
      else if (half_stb_o) half_seen_q <= 1'b1;
    end
  end

  AST_NO_COINCIDE: assert property (@(posedge clk_i) disable iff (!rst_ni) !(bit_stb_o && half_stb_o)); // R6
  AST_BIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) bit_stb_o |=> !bit_stb_o); // R5
  AST_HALF_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) half_stb_o |=> !half_stb_o); // R6
  AST_HALF_BEFORE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni) bit_stb_o |-> half_seen_q); // R6
  AST_PERIOD_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni) bit_stb_o |-> gap_q[0]); // R8
  AST_PERIOD_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni) gap_q <= 8'd127); // R8
endmodule

bind bitrate_div bitrate_div_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_stb_o  (bit_stb_o),
  .half_stb_o (half_stb_o)
);

// File: tb/tb_bitrate_div.sv
module tb_bitrate_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_mode_i = 1'b0;
  logic [5:0] rate_i = 6'd0;
  logic       bit_stb_o, half_stb_o;

  int total = 0, bad = 0;
  int mcnt = 0, mratio = 2;
  int nbit = 0, nhalf = 0, first_bit = 0, cyc = 0;

  always #2 clk_i = ~clk_i;

  bitrate_div dut (.*);

  function automatic int model_ratio(input logic ext, input logic [5:0] r);
    if (ext) return 2 * int'(r) + 2;
    case (r[2:0])
      3'd0: return 8;   3'd1: return 16;  3'd2: return 32;  3'd3: return 40;
      3'd4: return 50;  3'd5: return 64;  3'd6: return 100; default: return 128;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t act=%0d exp=%0d", tag, $time, act, exp);
    end
  endtask

  // sample after inputs settle, then advance the model across the next edge
  task automatic eval(input string tag);
    int eb, eh;
    #1;
    cyc++;
    if (mcnt == 0) mratio = model_ratio(ext_mode_i, rate_i);
    eb = (mcnt == mratio - 1);
    eh = (mcnt == mratio / 2 - 1);
    check({tag, " bit"}, int'(bit_stb_o), eb);
    check({tag, " half"}, int'(half_stb_o), eh);
    if (bit_stb_o) begin nbit++; if (first_bit == 0) first_bit = cyc; end
    if (half_stb_o) nhalf++;
    mcnt = eb ? 0 : mcnt + 1;
  endtask

  task automatic do_reset(input logic ext, input logic [5:0] r);
    @(negedge clk_i);
    rst_ni = 1'b0; ext_mode_i = ext; rate_i = r;
    #1;
    check("R1 reset bit", int'(bit_stb_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mcnt = 0; nbit = 0; nhalf = 0; first_bit = 0; cyc = 0;
    eval("R1");
  endtask

  task automatic step(input logic ext, input logic [5:0] r, input string tag);
    @(negedge clk_i);
    ext_mode_i = ext; rate_i = r;
    eval(tag);
  endtask

  task automatic run_cfg(input logic ext, input logic [5:0] r, input string tag);
    int rr;
    rr = model_ratio(ext, r);
    do_reset(ext, r);
    for (int k = 1; k < 3 * rr; k++) step(ext, r, tag);
    check("R1 first strobe cycle", first_bit, rr);
    check("R5 strobes per 3 periods", nbit, 3);
    check("R6 half strobes per 3 periods", nhalf, 3);
  endtask

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R2: every basic code
    for (int c = 0; c < 8; c++) run_cfg(1'b0, 6'(c), "R2");
    // R3: upper bits changing each cycle must not matter
    for (int c = 0; c < 8; c++) begin
      int rr;
      rr = model_ratio(1'b0, 6'(c));
      do_reset(1'b0, 6'(c));
      for (int k = 1; k < 2 * rr; k++) step(1'b0, {3'(k * 5 + c), 3'(c)}, "R3");
      check("R3 strobes", nbit, 2);
    end
    // R4: every extended code
    for (int n = 0; n < 64; n++) run_cfg(1'b1, 6'(n), "R4");
    // R7: long period, switch short mid-period; old ratio must finish
    do_reset(1'b1, 6'd9);
    for (int k = 1; k < 5; k++) step(1'b1, 6'd9, "R7");
    for (int k = 5; k < 20; k++) step(1'b1, 6'd0, "R7");
    check("R7 first period kept", first_bit, 20);
    for (int k = 0; k < 10; k++) step(1'b1, 6'd0, "R7");
    check("R7 new ratio applied", nbit, 6);
    // R7: mode and rate flips at irregular points
    do_reset(1'b0, 6'd0);
    for (int k = 1; k < 2000; k++)
      step(((k / 37) % 2) == 1, 6'((k / 23) * 7), "R7");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule